// File: doc/BRIEF.md
# Chunked FP32 Dot-Product Accumulator with Low-Bit Truncation

This block sums a stream of single-precision partial products into one dot-product result, as a hardware accumulator with limited precision would. Products arrive one per cycle with a valid strobe and a flag on the final product of each dot product. Products are gathered into chunks of K items in an inner sum. At each chunk boundary the inner sum can lose its low bits: a rounding increment is added to the raw 32-bit pattern as an unsigned integer, and then the lowest T bits are cleared. With T = 13, for example, a 23-bit fraction is cut to 10 bits.

The chunk result joins a running outer sum in one of two orders. In the first, the chunk is truncated and then added to the outer sum. In the second, the outer sum and the chunk are added first and the total is truncated. An optional range clamp reshapes the outer sum before each merge. It rounds the sum to a 16-bit float format (6-bit exponent, 9-bit fraction), sends magnitudes above that format's range to infinity and flushes magnitudes below it to zero. The result of each dot product appears on a registered output for one cycle.

Top module: `chunk_trunc_acc`

## Requirements
- R1: One cycle after a product with `in_last` set is accepted, `out_valid` is high for exactly one cycle and `out_data` holds the FP32 result. `out_valid` is low at all other times and is 0 after reset.
- R2: A chunk ends after K accepted products, where K = `cfg_chunk`. Any value below 16 is treated as 16.
- R3: At each chunk boundary with T = `cfg_trunc` > 0, the value being truncated becomes (bits + 2^(T-1)) AND NOT (2^T - 1) as 32-bit unsigned arithmetic. T = 0 leaves it unchanged, and T above 22 acts as 22.
- R4: With `cfg_order` = 0, each chunk merges as outer = outer + trunc(inner).
- R5: With `cfg_order` = 1, each chunk merges as outer = trunc(outer + inner), so the low T bits of the result are zero.
- R6: With `cfg_clamp` = 1, the outer sum is reshaped before every merge, while exponent-255 values pass unchanged. The reshaping first computes r = (bits + 0x2000) AND NOT 0x3FFF. If the magnitude bits [30:0] of r are at least 0x4FFFC000, the result is a signed infinity. If they are below 0x30004000, the result is a signed zero. Otherwise the result is r.
- R7: Additions round to nearest, ties to even. Subnormal inputs and results are flushed to zero, overflow gives a signed infinity, and exact cancellation gives +0.
- R8: A NaN operand, or the sum of opposite infinities, gives the quiet NaN 0x7FC00000.
- R9: A partial final chunk is still truncated and merged. The inner sum restarts at +0 for every chunk and the outer sum restarts at +0 for every dot product, so back-to-back dot products do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Product on `in_data` is accepted this cycle |
| in_data | input | 32 | FP32 partial product |
| in_last | input | 1 | Accepted product is the last of its dot product |
| cfg_trunc | input | 5 | Number of low bits truncated at chunk boundaries |
| cfg_chunk | input | CHUNK_W | Chunk length K (minimum 16) |
| cfg_order | input | 1 | 0: truncate then add; 1: add then truncate |
| cfg_clamp | input | 1 | Enable the 16-bit range clamp on the outer sum |
| out_valid | output | 1 | Result strobe |
| out_data | output | 32 | FP32 dot-product result |

## Verification
On every cycle, the assertions check the output timing against `in_last` and the chunk counter bound. They also check that the inner sum clears after each boundary, that the outer sum clears after each result, and that in add-then-truncate mode the truncated low bits of each result are zero. The numerical behaviour needs the bench's scenarios to show it. This covers the grouping by K including the minimum of 16, the rounding increment, the difference between the two merge orders, the clamp at both ends of its range, ties-to-even, flush-to-zero, overflow, and NaN and infinity handling.

// File: rtl/chunk_acc_pkg.sv
`timescale 1ns/1ps
package chunk_acc_pkg;
  localparam int FP_W      = 32;
  localparam int TRUNC_W   = 5;
  localparam int MAX_TRUNC = 22;
  typedef logic [FP_W-1:0] fp32_t;
  localparam fp32_t QNAN     = 32'h7FC0_0000;
  localparam logic [30:0] CLAMP_HI = 31'h4FFF_C000;
  localparam logic [30:0] CLAMP_LO = 31'h3000_4000;
  localparam fp32_t CLAMP_RND = 32'h0000_2000;
  localparam fp32_t CLAMP_LOW = 32'h0000_3FFF;
endpackage

// File: rtl/fca_fp32_add.sv
`timescale 1ns/1ps
module fca_fp32_add
  import chunk_acc_pkg::*;
(
  input  fp32_t a,
  input  fp32_t b,
  output fp32_t y
);
  function automatic logic [4:0] lead_zeros(input logic [26:0] v);
    logic [4:0] n;
    n = 5'd27;
    for (int i = 0; i < 27; i++) begin
      if (v[i]) n = 5'(26 - i);
    end
    return n;
  endfunction

  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero, swap, sub;
  fp32_t ax, bx, big, sml;
  logic [7:0]  diff;
  logic [5:0]  shamt;
  logic [49:0] ext, shifted;
  logic [26:0] ma, mb, m;
  logic [27:0] sum28;
  logic [4:0]  lz;
  logic signed [9:0] e;
  logic        up;
  logic [24:0] mr;
  logic [22:0] frac;

  always_comb begin
    a_nan  = (a[30:23] == 8'hFF) && (a[22:0] != '0);
    b_nan  = (b[30:23] == 8'hFF) && (b[22:0] != '0);
    a_inf  = (a[30:23] == 8'hFF) && (a[22:0] == '0);
    b_inf  = (b[30:23] == 8'hFF) && (b[22:0] == '0);
    a_zero = (a[30:23] == 8'h00);
    b_zero = (b[30:23] == 8'h00);
    ax     = a_zero ? {a[31], 31'b0} : a;
    bx     = b_zero ? {b[31], 31'b0} : b;
    swap   = bx[30:0] > ax[30:0];
    big    = swap ? bx : ax;
    sml    = swap ? ax : bx;
    sub    = big[31] ^ sml[31];
    diff   = big[30:23] - sml[30:23];
    shamt  = (diff > 8'd40) ? 6'd40 : diff[5:0];
    ext    = (sml[30:23] == 8'h00) ? '0 : {1'b1, sml[22:0], 26'b0};
    shifted = ext >> shamt;
    mb     = {shifted[49:24], shifted[23] | (|shifted[22:0])};
    ma     = {1'b1, big[22:0], 3'b0};
    sum28  = sub ? ({1'b0, ma} - {1'b0, mb}) : ({1'b0, ma} + {1'b0, mb});
    e      = signed'({2'b00, big[30:23]});
    lz     = '0;
    if (!sub && sum28[27]) begin
      m = {sum28[27:2], sum28[1] | sum28[0]};
      e = e + 10'sd1;
    end else begin
      lz = lead_zeros(sum28[26:0]);
      m  = sum28[26:0] << lz;
      e  = e - signed'({5'b0, lz});
    end
    up = m[2] & (m[1] | m[0] | m[3]);
    mr = {1'b0, m[26:3]} + {24'b0, up};
    if (mr[24]) begin
      e    = e + 10'sd1;
      frac = mr[23:1];
    end else begin
      frac = mr[22:0];
    end
    if (a_nan || b_nan || (a_inf && b_inf && (a[31] != b[31])))
      y = QNAN;
    else if (a_inf)
      y = a;
    else if (b_inf)
      y = b;
    else if (ax[30:0] == '0 && bx[30:0] == '0)
      y = {ax[31] & bx[31], 31'b0};
    else if (sum28 == '0)
      y = '0;
    else if (e >= 10'sd255)
      y = {big[31], 8'hFF, 23'b0};
    else if (e <= 10'sd0)
      y = {big[31], 31'b0};
    else
      y = {big[31], e[7:0], frac};
  end
endmodule

// File: rtl/fca_round_mask.sv
`timescale 1ns/1ps
module fca_round_mask
  import chunk_acc_pkg::*;
(
  input  fp32_t              x,
  input  logic [TRUNC_W-1:0] t,
  output fp32_t              y
);
  fp32_t inc, keep;
  always_comb begin
    inc  = (t == '0) ? '0 : (fp32_t'(1) << (t - 1'b1));
    keep = ~((fp32_t'(1) << t) - fp32_t'(1));
    y    = (t == '0) ? x : ((x + inc) & keep);
  end
endmodule

// File: rtl/fca_range_clamp.sv
`timescale 1ns/1ps
module fca_range_clamp
  import chunk_acc_pkg::*;
(
  input  logic  en,
  input  fp32_t x,
  output fp32_t y
);
  fp32_t r;
  always_comb begin
    r = (x + CLAMP_RND) & ~CLAMP_LOW;
    if (!en || x[30:23] == 8'hFF)
      y = x;
    else if (r[30:0] >= CLAMP_HI)
      y = {x[31], 8'hFF, 23'b0};
    else if (r[30:0] < CLAMP_LO)
      y = {x[31], 31'b0};
    else
      y = r;
  end
endmodule

// File: rtl/chunk_trunc_acc.sv
`timescale 1ns/1ps
module chunk_trunc_acc
  import chunk_acc_pkg::*;
#(
  parameter int CHUNK_W   = 8,
  parameter int MIN_CHUNK = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [31:0]        in_data,
  input  logic               in_last,
  input  logic [TRUNC_W-1:0] cfg_trunc,
  input  logic [CHUNK_W-1:0] cfg_chunk,
  input  logic               cfg_order,
  input  logic               cfg_clamp,
  output logic               out_valid,
  output logic [31:0]        out_data
);
  localparam logic [CHUNK_W-1:0] MIN_K = CHUNK_W'(MIN_CHUNK);

  logic [CHUNK_W-1:0] cnt, k_eff;
  logic [TRUNC_W-1:0] t_eff;
  fp32_t inner, outer, sum_in, outer_c, chunk_rm, merge_b, merge_sum, merge_rm, merged;
  logic  boundary;

  assign k_eff    = (cfg_chunk < MIN_K) ? MIN_K : cfg_chunk;
  assign t_eff    = (cfg_trunc > TRUNC_W'(MAX_TRUNC)) ? TRUNC_W'(MAX_TRUNC) : cfg_trunc;
  assign boundary = in_last || (cnt == k_eff - 1'b1);

  fca_fp32_add    u_add_inner (.a(inner),   .b(in_data),  .y(sum_in));
  fca_range_clamp u_clamp     (.en(cfg_clamp), .x(outer), .y(outer_c));
  fca_round_mask  u_rm_chunk  (.x(sum_in),  .t(t_eff),    .y(chunk_rm));
  assign merge_b = cfg_order ? sum_in : chunk_rm;
  fca_fp32_add    u_add_merge (.a(outer_c), .b(merge_b),  .y(merge_sum));
  fca_round_mask  u_rm_merge  (.x(merge_sum), .t(t_eff),  .y(merge_rm));
  assign merged  = cfg_order ? merge_rm : merge_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      inner     <= '0;
      outer     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (boundary) begin
          cnt   <= '0;
          inner <= '0;
          if (in_last) begin
            outer     <= '0;
            out_valid <= 1'b1;
            out_data  <= merged;
          end else begin
            outer <= merged;
          end
        end else begin
          cnt   <= cnt + 1'b1;
          inner <= sum_in;
        end
      end
    end
  end

  AST_RESULT_STROBE: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> out_valid); // R1
  AST_NO_SPURIOUS_OUT: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_last) |=> !out_valid); // R1
  AST_CHUNK_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < k_eff); // R2
  AST_INNER_RESTART: assert property (@(posedge clk) disable iff (rst)
    (in_valid && boundary) |=> (inner == '0)); // R9
  AST_OUTER_RESTART: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> (outer == '0)); // R9
  AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && cfg_order && t_eff != '0) |=>
      ((out_data & ((32'd1 << $past(t_eff)) - 32'd1)) == '0)); // R5
endmodule

// File: tb/chunk_trunc_acc_test.sv
`timescale 1ns/1ps
module chunk_trunc_acc_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic [4:0]  cfg_trunc = '0;
  logic [7:0]  cfg_chunk = 8'd16;
  logic        cfg_order = 1'b0;
  logic        cfg_clamp = 1'b0;
  logic        out_valid;
  logic [31:0] out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] stim[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  chunk_trunc_acc uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .cfg_trunc(cfg_trunc), .cfg_chunk(cfg_chunk), .cfg_order(cfg_order),
    .cfg_clamp(cfg_clamp), .out_valid(out_valid), .out_data(out_data));

  function automatic real inf_r();
    return $bitstoreal(64'h7FF0_0000_0000_0000);
  endfunction

  function automatic real f2r(input logic [31:0] b);
    int  e;
    real m;
    e = int'(b[30:23]);
    if (e == 0) return 0.0;
    if (e == 255) return b[31] ? -inf_r() : inf_r();
    m = (1.0 + real'(b[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return b[31] ? -m : m;
  endfunction

  function automatic logic [31:0] r2f(input real v);
    logic s;
    real  a;
    int   e, eb, fr;
    if (v == 0.0) return 32'h0;
    s = (v < 0.0);
    a = s ? -v : v;
    if (a > 3.4028235e38) return {s, 8'hFF, 23'h0};
    e = 0;
    while (a >= 2.0) begin a = a / 2.0; e++; end
    while (a < 1.0) begin a = a * 2.0; e--; end
    fr = $rtoi((a - 1.0) * 8388608.0);
    eb = e + 127;
    if (eb <= 0) return {s, 31'h0};
    return {s, eb[7:0], fr[22:0]};
  endfunction

  function automatic logic [31:0] rmb(input logic [31:0] x, input int t);
    logic [31:0] inc, keep;
    if (t == 0) return x;
    inc  = 32'd1 << (t - 1);
    keep = ~((32'd1 << t) - 32'd1);
    return (x + inc) & keep;
  endfunction

  function automatic logic [31:0] clampb(input logic [31:0] x);
    logic [31:0] r;
    if (x[30:23] == 8'hFF) return x;
    r = (x + 32'h2000) & ~32'h3FFF;
    if (r[30:0] >= 31'h4FFF_C000) return {x[31], 8'hFF, 23'h0};
    if (r[30:0] < 31'h3000_4000) return {x[31], 31'h0};
    return r;
  endfunction

  function automatic logic [31:0] model(input int k, input int t, input bit ord, input bit clp);
    real inner, outer, oc;
    int  cnt, kk, tt;
    kk = (k < 16) ? 16 : k;
    tt = (t > 22) ? 22 : t;
    inner = 0.0; outer = 0.0; cnt = 0;
    for (int i = 0; i < stim.size(); i++) begin
      inner = inner + f2r(stim[i]);
      if (cnt == kk - 1 || i == stim.size() - 1) begin
        oc = clp ? f2r(clampb(r2f(outer))) : outer;
        if (!ord) outer = oc + f2r(rmb(r2f(inner), tt));
        else      outer = f2r(rmb(r2f(oc + inner), tt));
        inner = 0.0;
        cnt = 0;
      end else begin
        cnt++;
      end
    end
    return r2f(outer);
  endfunction

  task automatic run_dot(input int k, input int t, input bit ord, input bit clp,
                         input string tag, input bit direct, input logic [31:0] exp_d);
    logic [31:0] ex;
    ex = direct ? exp_d : model(k, t, ord, clp);
    exp_q.push_back(ex);
    tag_q.push_back(tag);
    @(negedge clk);
    cfg_chunk = 8'(k); cfg_trunc = 5'(t); cfg_order = ord; cfg_clamp = clp;
    for (int i = 0; i < stim.size(); i++) begin
      if (i != 0) @(negedge clk);
      in_valid = 1'b1;
      in_data  = stim[i];
      in_last  = (i == stim.size() - 1);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
    end
  endtask

  task automatic fill(input logic [31:0] v, input int n);
    for (int i = 0; i < n; i++) stim.push_back(v);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected result, actual %h expected no output", out_data);
      end else begin
        logic [31:0] ex;
        string tg;
        ex = exp_q.pop_front();
        tg = tag_q.pop_front();
        if (out_data !== ex) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", tg, out_data, ex);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || out_data !== 32'h0) begin
      errors++;
      $display("FAIL R1: reset state actual %b/%h expected 0/00000000", out_valid, out_data);
    end
    rst = 1'b0;
    idle(2);

    // R1 / R9: integers 1..20, partial second chunk
    stim.delete();
    for (int i = 1; i <= 20; i++) stim.push_back(r2f(real'(i)));
    run_dot(16, 0, 0, 0, "R1", 1, r2f(210.0));
    idle(2);
    run_dot(16, 0, 0, 0, "R9 partial chunk", 0, '0);
    // R9: back-to-back dot product with no gap
    stim.delete();
    fill(r2f(2.5), 3);
    run_dot(16, 0, 0, 0, "R9 back-to-back", 1, r2f(7.5));
    idle(2);

    // R2: chunk length, minimum of 16
    stim.delete();
    fill(32'h3F80_1000, 20);
    run_dot(4, 13, 0, 0, "R2 K below minimum", 0, '0);
    idle(2);
    run_dot(20, 13, 0, 0, "R2 K=20", 0, '0);
    idle(2);
    // R3: T=0 leaves sums exact
    run_dot(16, 0, 0, 0, "R3 T=0", 1, r2f(20.0 + 20.0 / 2048.0));
    idle(2);
    // R3: T above 22 saturates
    stim.delete();
    fill(r2f(1.25), 3);
    fill(r2f(0.375), 17);
    run_dot(16, 31, 0, 0, "R3 T saturates", 0, '0);
    idle(2);

    // R4 / R5: merge orders on mixed-sign values
    stim.delete();
    fill(32'h3F80_1000, 16);
    stim.push_back(r2f(-3.5));
    fill(r2f(0.0078125), 16);
    stim.push_back(32'h3F80_1000);
    run_dot(16, 13, 0, 0, "R4", 0, '0);
    idle(1);
    run_dot(16, 13, 1, 0, "R5", 0, '0);
    idle(1);
    run_dot(16, 9, 1, 0, "R5 T=9", 0, '0);
    idle(2);

    // R6: clamp at the top of the range
    stim.delete();
    fill(32'h4E00_0000, 16);
    stim.push_back(32'h4480_0000);
    run_dot(16, 0, 0, 1, "R6 max to inf", 1, 32'h7F80_0000);
    idle(1);
    run_dot(16, 0, 0, 0, "R6 clamp off high", 0, '0);
    idle(1);
    // R6: clamp at the bottom of the range
    stim.delete();
    fill(32'h2980_0000, 16);
    stim.push_back(32'h2B80_0000);
    run_dot(16, 0, 0, 1, "R6 min to zero", 1, 32'h2B80_0000);
    idle(1);
    run_dot(16, 0, 0, 0, "R6 clamp off low", 1, 32'h2C00_0000);
    idle(2);

    // R7: ties to even, flush to zero, overflow, cancellation
    stim.delete();
    stim.push_back(32'h4B80_0000); stim.push_back(r2f(1.0));
    run_dot(16, 0, 0, 0, "R7 tie down", 1, 32'h4B80_0000);
    stim.delete();
    stim.push_back(32'h4B80_0000); stim.push_back(r2f(3.0));
    run_dot(16, 0, 0, 0, "R7 tie up", 1, 32'h4B80_0002);
    stim.delete();
    stim.push_back(32'h0040_0000); stim.push_back(32'h0040_0000);
    run_dot(16, 0, 0, 0, "R7 flush subnormal", 1, 32'h0000_0000);
    stim.delete();
    stim.push_back(32'h7F00_0000); stim.push_back(32'h7F00_0000);
    run_dot(16, 0, 0, 0, "R7 overflow", 1, 32'h7F80_0000);
    stim.delete();
    stim.push_back(r2f(5.0)); stim.push_back(r2f(-5.0));
    run_dot(16, 0, 0, 0, "R7 cancel", 1, 32'h0000_0000);
    idle(2);

    // R8: NaN and opposite infinities
    stim.delete();
    stim.push_back(r2f(1.0)); stim.push_back(32'h7FA0_0001); stim.push_back(r2f(2.0));
    run_dot(16, 4, 0, 0, "R8 NaN", 1, 32'h7FC0_0000);
    stim.delete();
    stim.push_back(32'h7F80_0000); stim.push_back(32'hFF80_0000);
    run_dot(16, 0, 1, 0, "R8 inf minus inf", 1, 32'h7FC0_0000);
    idle(6);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1: results missing, actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule